// File: doc/BRIEF.md
# Received-Frame Location and Type Screen

This block is one state of a larger receive controller. While the shared 3-bit controller state holds 3'b011, it pulls the start of a received frame out of an external Ethernet controller, one byte per register access. Each access is a Go/Done handshake. The block counts bytes to step over the 14-byte frame header. It then compares the first payload byte against the board's hard-wired slot number, where 0xFF matches any slot. The second payload byte is the application packet type, which is separate from the Ethernet type field.

From these two bytes the block makes one of two decisions. In the first, it drops the frame from the controller's receive buffer by writing 0x02 to register 0x11, then returns the shared state to idle (3'b010). This happens for wrong locations, unknown types, and Reset or Query requests; a Reset or Query also raises a one-cycle request pulse. In the second, it leaves the frame in the buffer with the read pointer on byte 17 and hands the shared state to the Soft Reset handler (3'b100) or the Programmer handler (3'b101).

Top module: `frame_screen`

## Requirements
- R1: After reset, and whenever `st_cur` is not 3'b011, the block starts no access (`xc_go` low) and does not write the state register (`st_we` low).
- R2: `xc_go` is a one-cycle pulse, and a new pulse is never raised before `xc_done` has answered the previous access.
- R3: Byte reads use `xc_rd` high with `xc_addr` equal to 8'h01. The first 14 bytes read are header bytes, and their values have no effect on the outcome.
- R4: The 15th byte is accepted when it equals `slot_id` or 8'hFF. Otherwise the frame is discarded after exactly 15 reads and `st_next` is 3'b010. A discard is one write (`xc_rd` low) of 8'h02 to address 8'h11.
- R5: Type byte 8'h53 (ASCII 'S') causes no write, 16 reads in total, and a hand-off with `st_next` 3'b100.
- R6: Type byte 8'h50 (ASCII 'P') causes no write, 16 reads in total, and a hand-off with `st_next` 3'b101.
- R7: Type byte 8'h52 ('R') or 8'h51 ('Q') causes a discard write followed by a hand-off to 3'b010. In the hand-off cycle, `rst_req` ('R') or `qry_req` ('Q') is high for one cycle.
- R8: Any other type byte causes a discard write, a hand-off to 3'b010, and no request pulse.
- R9: Each frame produces exactly one `st_we` pulse of one cycle. Any discard write has completed before that pulse.
- R10: The byte count and the internal phase restart on every entry into 3'b011, so consecutive frames are each counted from their first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| st_cur | input | 3 | Current value of the shared controller state register |
| st_we | output | 1 | Write enable for the shared state register |
| st_next | output | 3 | Value written to the shared state register |
| slot_id | input | 8 | Hard-wired slot location of this board |
| xc_go | output | 1 | Starts one controller register access |
| xc_rd | output | 1 | High for a read access, low for a write |
| xc_addr | output | 8 | Controller register address |
| xc_wdata | output | 8 | Controller register write value |
| xc_rdata | input | 8 | Controller register read value, valid with `xc_done` |
| xc_done | input | 1 | Completion strobe for the current access |
| rst_req | output | 1 | One-cycle Reset request pulse |
| qry_req | output | 1 | One-cycle Query request pulse |

## Verification
The assertions assume that `xc_done` answers each `xc_go` exactly once, at least one cycle later and never while no access is open. They also assume that `st_cur` only leaves 3'b011 through the block's own `st_we`. The bench's controller model answers every access after a random delay of one to four cycles, and it changes the state register only on `st_we` or on an explicit frame start. Frames are started only from idle or handler states, after the previous hand-off has settled.

// File: rtl/frame_screen.sv
module frame_screen #(
  parameter int         HDR_BYTES = 14,
  parameter logic [2:0] ST_SELF   = 3'b011,
  parameter logic [2:0] ST_IDLE   = 3'b010,
  parameter logic [2:0] ST_SOFT   = 3'b100,
  parameter logic [2:0] ST_PROG   = 3'b101,
  parameter logic [7:0] RD_ADDR   = 8'h01,
  parameter logic [7:0] DISC_ADDR = 8'h11,
  parameter logic [7:0] DISC_VAL  = 8'h02,
  parameter logic [7:0] LOC_ANY   = 8'hFF,
  parameter logic [7:0] TY_RST    = 8'h52,
  parameter logic [7:0] TY_QRY    = 8'h51,
  parameter logic [7:0] TY_SOFT   = 8'h53,
  parameter logic [7:0] TY_PROG   = 8'h50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] st_cur,
  output logic       st_we,
  output logic [2:0] st_next,
  input  logic [7:0] slot_id,
  output logic       xc_go,
  output logic       xc_rd,
  output logic [7:0] xc_addr,
  output logic [7:0] xc_wdata,
  input  logic [7:0] xc_rdata,
  input  logic       xc_done,
  output logic       rst_req,
  output logic       qry_req
);
  localparam int CW = $clog2(HDR_BYTES + 3);
  localparam logic [CW-1:0] LOC_IDX = CW'(HDR_BYTES);
  localparam logic [CW-1:0] TYP_IDX = CW'(HDR_BYTES + 1);

  typedef enum logic [2:0] {P_OFF, P_ISSUE, P_WAIT, P_DISC, P_DWAIT, P_HAND, P_HOLD} phase_t;
  typedef enum logic [1:0] {K_NONE, K_RST, K_QRY} kind_t;

  phase_t        ph;
  kind_t         kind;
  logic [CW-1:0] cnt;
  logic [2:0]    dest;
  logic          was_active;
  logic          active, entry, loc_ok, writing;

  assign active  = (st_cur == ST_SELF);
  assign entry   = active && !was_active;
  assign loc_ok  = (xc_rdata == slot_id) || (xc_rdata == LOC_ANY);
  assign writing = (ph == P_DISC) || (ph == P_DWAIT);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      was_active <= 1'b0;
      ph         <= P_OFF;
      cnt        <= '0;
      dest       <= ST_IDLE;
      kind       <= K_NONE;
    end else begin
      was_active <= active;
      if (!active) begin
        ph <= P_OFF;
      end else if (entry) begin
        ph   <= P_ISSUE;
        cnt  <= '0;
        dest <= ST_IDLE;
        kind <= K_NONE;
      end else begin
        case (ph)
          P_ISSUE: ph <= P_WAIT;
          P_WAIT: if (xc_done) begin
            cnt <= cnt + 1'b1;
            if (cnt == LOC_IDX && !loc_ok) begin
              dest <= ST_IDLE;
              ph   <= P_DISC;
            end else if (cnt == TYP_IDX) begin
              case (xc_rdata)
                TY_SOFT: begin dest <= ST_SOFT; ph <= P_HAND; end
                TY_PROG: begin dest <= ST_PROG; ph <= P_HAND; end
                TY_RST:  begin dest <= ST_IDLE; kind <= K_RST; ph <= P_DISC; end
                TY_QRY:  begin dest <= ST_IDLE; kind <= K_QRY; ph <= P_DISC; end
                default: begin dest <= ST_IDLE; ph <= P_DISC; end
              endcase
            end else begin
              ph <= P_ISSUE;
            end
          end
          P_DISC:  ph <= P_DWAIT;
          P_DWAIT: if (xc_done) ph <= P_HAND;
          P_HAND:  ph <= P_HOLD;
          default: ;
        endcase
      end
    end
  end

  assign xc_go    = active && ((ph == P_ISSUE) || (ph == P_DISC));
  assign xc_rd    = !writing;
  assign xc_addr  = writing ? DISC_ADDR : RD_ADDR;
  assign xc_wdata = writing ? DISC_VAL : 8'h00;
  assign st_we    = active && (ph == P_HAND);
  assign st_next  = dest;
  assign rst_req  = st_we && (kind == K_RST);
  assign qry_req  = st_we && (kind == K_QRY);
endmodule

module frame_screen_chk #(
  parameter logic [2:0] ST_SELF   = 3'b011,
  parameter logic [2:0] ST_IDLE   = 3'b010,
  parameter logic [2:0] ST_SOFT   = 3'b100,
  parameter logic [2:0] ST_PROG   = 3'b101,
  parameter logic [7:0] RD_ADDR   = 8'h01,
  parameter logic [7:0] DISC_ADDR = 8'h11,
  parameter logic [7:0] DISC_VAL  = 8'h02
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] st_cur,
  input logic       st_we,
  input logic [2:0] st_next,
  input logic       xc_go,
  input logic       xc_rd,
  input logic [7:0] xc_addr,
  input logic [7:0] xc_wdata,
  input logic       xc_done,
  input logic       rst_req,
  input logic       qry_req
);
  logic open_acc;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) open_acc <= 1'b0;
    else if (xc_go) open_acc <= 1'b1;
    else if (xc_done) open_acc <= 1'b0;
  end

  // R1
  quiet_away_chk: assert property (@(posedge clk) disable iff (rst)
    (st_cur != ST_SELF) |-> (!xc_go && !st_we));
  // R2
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst) xc_go |=> !xc_go);
  // R2
  go_after_done_chk: assert property (@(posedge clk) disable iff (rst) xc_go |-> !open_acc);
  // R3
  read_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (xc_go && xc_rd) |-> (xc_addr == RD_ADDR));
  // R4
  discard_write_chk: assert property (@(posedge clk) disable iff (rst)
    (xc_go && !xc_rd) |-> (xc_addr == DISC_ADDR && xc_wdata == DISC_VAL));
  // R7
  req_with_we_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_req || qry_req) |-> (st_we && st_next == ST_IDLE && !(rst_req && qry_req)));
  // R9
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst) st_we |=> !st_we);
  // R9
  we_settled_chk: assert property (@(posedge clk) disable iff (rst) st_we |-> !open_acc);
  // R5
  we_target_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (st_next == ST_IDLE || st_next == ST_SOFT || st_next == ST_PROG));
endmodule

bind frame_screen frame_screen_chk #(
  .ST_SELF(ST_SELF), .ST_IDLE(ST_IDLE), .ST_SOFT(ST_SOFT), .ST_PROG(ST_PROG),
  .RD_ADDR(RD_ADDR), .DISC_ADDR(DISC_ADDR), .DISC_VAL(DISC_VAL)
) u_frame_screen_chk (
  .clk(clk), .rst(rst), .st_cur(st_cur), .st_we(st_we), .st_next(st_next),
  .xc_go(xc_go), .xc_rd(xc_rd), .xc_addr(xc_addr), .xc_wdata(xc_wdata),
  .xc_done(xc_done), .rst_req(rst_req), .qry_req(qry_req)
);

// File: tb/test_frame_screen.sv
`timescale 1ns/1ps
module test_frame_screen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_q;
  logic       st_we;
  logic [2:0] st_next;
  logic [7:0] slot_id = 8'h00;
  logic       xc_go, xc_rd;
  logic [7:0] xc_addr, xc_wdata;
  logic [7:0] xc_rdata = 8'h00;
  logic       xc_done = 1'b0;
  logic       rst_req, qry_req;

  frame_screen i_frame_screen (
    .clk(clk), .rst(rst), .st_cur(reg_q), .st_we(st_we), .st_next(st_next),
    .slot_id(slot_id), .xc_go(xc_go), .xc_rd(xc_rd), .xc_addr(xc_addr),
    .xc_wdata(xc_wdata), .xc_rdata(xc_rdata), .xc_done(xc_done),
    .rst_req(rst_req), .qry_req(qry_req)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic kick = 1'b0;
  logic clr  = 1'b0;
  logic [7:0] frame [0:23];

  always @(posedge clk) begin
    if (rst) reg_q <= 3'b010;
    else if (kick) reg_q <= 3'b011;
    else if (st_we) reg_q <= st_next;
  end

  logic       pend = 1'b0;
  logic [1:0] lat = 2'd0;
  logic [7:0] held = 8'h00;
  logic       go_prev = 1'b0;
  int rptr = 0, n_rd = 0, n_wr = 0, n_we = 0, n_rreq = 0, n_qreq = 0;
  int viol = 0, wr_before_we = 0, req_off_we = 0;
  logic [7:0] w_addr = 8'h00, w_data = 8'h00;
  logic [2:0] we_val = 3'b000;

  always @(posedge clk) begin
    xc_done <= 1'b0;
    go_prev <= xc_go;
    if (clr) begin
      rptr <= 0; n_rd <= 0; n_wr <= 0; n_we <= 0; n_rreq <= 0; n_qreq <= 0;
      viol <= 0; wr_before_we <= 0; req_off_we <= 0;
    end else begin
      if (xc_go) begin
        if (pend || go_prev) viol <= viol + 1;
        pend <= 1'b1;
        lat  <= 2'($urandom_range(3, 0));
        if (xc_rd) begin
          held <= frame[rptr];
          rptr <= rptr + 1;
          n_rd <= n_rd + 1;
        end else begin
          n_wr   <= n_wr + 1;
          w_addr <= xc_addr;
          w_data <= xc_wdata;
        end
      end else if (pend) begin
        if (lat == 2'd0) begin
          xc_done  <= 1'b1;
          xc_rdata <= held;
          pend     <= 1'b0;
        end else lat <= lat - 2'd1;
      end
      if (st_we) begin
        n_we <= n_we + 1;
        we_val <= st_next;
        wr_before_we <= n_wr;
      end
      if (rst_req) n_rreq <= n_rreq + 1;
      if (qry_req) n_qreq <= n_qreq + 1;
      if ((rst_req || qry_req) && !st_we) req_off_we <= req_off_we + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit loc_ok(input logic [7:0] loc, input logic [7:0] slot);
    return (loc == slot) || (loc == 8'hFF);
  endfunction

  function automatic int exp_reads(input logic [7:0] loc, input logic [7:0] slot);
    return loc_ok(loc, slot) ? 16 : 15;
  endfunction

  function automatic int exp_next(input logic [7:0] loc, input logic [7:0] ty, input logic [7:0] slot);
    if (!loc_ok(loc, slot)) return 2;
    if (ty == 8'h53) return 4;
    if (ty == 8'h50) return 5;
    return 2;
  endfunction

  function automatic int exp_writes(input logic [7:0] loc, input logic [7:0] ty, input logic [7:0] slot);
    if (loc_ok(loc, slot) && (ty == 8'h53 || ty == 8'h50)) return 0;
    return 1;
  endfunction

  function automatic string tag_of(input logic [7:0] loc, input logic [7:0] ty, input logic [7:0] slot);
    if (!loc_ok(loc, slot)) return "R4";
    case (ty)
      8'h53: return "R5";
      8'h50: return "R6";
      8'h52, 8'h51: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_frame(input logic [7:0] loc, input logic [7:0] ty,
                           input logic [7:0] slot, input bit trap_hdr, input string extra);
    string t;
    int    wt;
    t = tag_of(loc, ty, slot);
    @(negedge clk);
    for (int i = 0; i < 24; i++) frame[i] = 8'($urandom);
    if (trap_hdr)
      for (int i = 0; i < 14; i++) frame[i] = (i % 2 == 0) ? 8'hFF : 8'h53;
    frame[14] = loc;
    frame[15] = ty;
    slot_id = slot;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    wt = 0;
    while (reg_q == 3'b011 && wt < 500) begin
      @(negedge clk);
      wt++;
    end
    repeat (3) @(negedge clk);
    chk(t, "frame finished", int'(wt < 500), 1);
    chk(t, {"reads ", extra}, n_rd, exp_reads(loc, slot));
    chk(t, "discard writes", n_wr, exp_writes(loc, ty, slot));
    if (exp_writes(loc, ty, slot) == 1) begin
      chk("R4", "discard addr", int'(w_addr), 32'h11);
      chk("R4", "discard data", int'(w_data), 32'h02);
    end
    chk(t, "state written", int'(reg_q), exp_next(loc, ty, slot));
    chk("R9", "we pulses", n_we, 1);
    chk("R9", "writes before we", wr_before_we, exp_writes(loc, ty, slot));
    chk("R7", "reset requests", n_rreq, int'(loc_ok(loc, slot) && ty == 8'h52));
    chk("R7", "query requests", n_qreq, int'(loc_ok(loc, slot) && ty == 8'h51));
    chk("R7", "request off hand-off", req_off_we, 0);
    chk("R2", "go protocol violations", viol, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int gos;
    int wes;
    logic [7:0] s, l, ty;
    void'($urandom(32'd1234));
    clr = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    clr = 1'b0;
    gos = 0;
    wes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      gos += int'(xc_go);
      wes += int'(st_we);
    end
    chk("R1", "go while idle", gos, 0);
    chk("R1", "we while idle", wes, 0);
    chk("R1", "state after reset", int'(reg_q), 2);

    run_frame(8'h07, 8'h53, 8'h07, 1'b0, "");
    run_frame(8'hFF, 8'h50, 8'h07, 1'b0, "");
    run_frame(8'h07, 8'h52, 8'h07, 1'b0, "");
    run_frame(8'h07, 8'h51, 8'h07, 1'b0, "");
    run_frame(8'h08, 8'h53, 8'h07, 1'b0, "");
    run_frame(8'h07, 8'h58, 8'h07, 1'b0, "");
    run_frame(8'h21, 8'h50, 8'h20, 1'b1, "R3 header trap");
    run_frame(8'h20, 8'h50, 8'h20, 1'b1, "R3 header trap");
    run_frame(8'h33, 8'h53, 8'h33, 1'b0, "R10 back to back");
    run_frame(8'h33, 8'h50, 8'h33, 1'b0, "R10 back to back");
    run_frame(8'h34, 8'h52, 8'h33, 1'b0, "R10 back to back");

    for (int n = 0; n < 80; n++) begin
      s = 8'($urandom);
      case ($urandom_range(2, 0))
        0: l = s;
        1: l = 8'hFF;
        default: l = 8'($urandom);
      endcase
      case ($urandom_range(4, 0))
        0: ty = 8'h52;
        1: ty = 8'h51;
        2: ty = 8'h53;
        3: ty = 8'h50;
        default: ty = 8'($urandom);
      endcase
      run_frame(l, ty, s, 1'b0, "R3 random");
    end
    finish_run();
  end
endmodule